// File: doc/BRIEF.md
# Burst Address Counter

This block produces the word address for a burst-capable synchronous memory. A start strobe captures a full external address and sets the position within the burst to zero. Each later advance request steps to the next word of the aligned four-word group that holds the start address. Only the two lowest address bits move during a burst. They follow either an XOR-based interleaved order or a linear order that wraps modulo four.

The order is chosen by a mode input that is meant to be tied off or held static. A hold condition (advance not requested) keeps the present address. The output is a registered word address that feeds the memory array's decoders.

Top module: `burst_addr_gen`

## Requirements
- R1: When `load_i` is high at a rising edge, `word_addr_o` takes the value of `ext_addr_i` on that edge, and the burst position returns to zero, so the next advance yields the second word of the sequence.
- R2: With `ilv_mode_i` = 1 (interleaved), the low two bits after advance k (k = 0..3) equal the loaded low bits XOR k. Starting from low bits 01, the order is 01, 00, 11, 10.
- R3: With `ilv_mode_i` = 0 (linear), the low two bits after advance k equal the loaded low bits plus k, modulo 4. Starting from 10, the order is 10, 11, 00, 01.
- R4: Bits `ADDR_W-1` down to 2 of `word_addr_o` stay constant between loads. No carry passes out of the two-bit field, even when linear order wraps from 11 to 00.
- R5: An advance happens only when `adv_n_i` is low and `load_i` is low. With `adv_n_i` high and `load_i` low, `word_addr_o` holds its value.
- R6: After the fourth word, the position wraps, and further advances repeat the same four-word sequence.
- R7: If `load_i` is high and `adv_n_i` is low on the same edge, the load wins: `word_addr_o` becomes exactly `ext_addr_i`.
- R8: A synchronous active-high `rst_i` clears `word_addr_o` to zero, and the output changes only at rising clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; all state updates on the rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| load_i | input | 1 | Begin-burst strobe; captures `ext_addr_i` |
| adv_n_i | input | 1 | Advance request, active low |
| ilv_mode_i | input | 1 | Order select: 1 interleaved, 0 linear; static |
| ext_addr_i | input | ADDR_W | External start address |
| word_addr_o | output | ADDR_W | Registered current word address |

## Verification
Bursts are started at every low-bit phase that tells the two orders apart. Interleaved runs from low bits 01 reverse the pairwise order, which linear counting never does. Linear runs from 10 and from 11 expose any carry leaking into bit 2 and above, and the upper field is set to all ones so that such a leak is visible. Runs extended past four advances separate a true wrap from a saturating or free-running count. Hold stretches inserted mid-burst, and a restart issued together with an advance, show that the position is frozen and cleared exactly when required.

// File: rtl/burst_addr_gen.sv
module burst_addr_gen #(
  parameter int ADDR_W = 18
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              load_i,
  input  logic              adv_n_i,
  input  logic              ilv_mode_i,
  input  logic [ADDR_W-1:0] ext_addr_i,
  output logic [ADDR_W-1:0] word_addr_o
);
  logic [1:0] base_lo_q;
  logic [1:0] pos_q;
  logic [1:0] pos_nx;
  logic [1:0] lo_nx;
  logic       step;

  assign step   = !adv_n_i && !load_i;
  assign pos_nx = pos_q + 2'd1;
  assign lo_nx  = ilv_mode_i ? (base_lo_q ^ pos_nx) : (base_lo_q + pos_nx);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      base_lo_q   <= '0;
      pos_q       <= '0;
      word_addr_o <= '0;
    end else if (load_i) begin
      base_lo_q   <= ext_addr_i[1:0];
      pos_q       <= '0;
      word_addr_o <= ext_addr_i;
    end else if (step) begin
      pos_q       <= pos_nx;
      word_addr_o <= {word_addr_o[ADDR_W-1:2], lo_nx};
    end
  end
endmodule

module burst_addr_gen_chk #(
  parameter int ADDR_W = 18
) (
  input logic              clk_i,
  input logic              rst_i,
  input logic              load_i,
  input logic              adv_n_i,
  input logic              ilv_mode_i,
  input logic [ADDR_W-1:0] ext_addr_i,
  input logic [ADDR_W-1:0] word_addr_o
);
  AST_LOAD_CAPTURE: assert property (@(posedge clk_i) disable iff (rst_i)
    load_i |=> word_addr_o == $past(ext_addr_i)); // R1
  AST_ILV_BIT0_FLIP: assert property (@(posedge clk_i) disable iff (rst_i)
    (!load_i && !adv_n_i && ilv_mode_i) |=> word_addr_o[0] != $past(word_addr_o[0])); // R2
  AST_LIN_STEP: assert property (@(posedge clk_i) disable iff (rst_i)
    (!load_i && !adv_n_i && !ilv_mode_i) |=> word_addr_o[1:0] == $past(word_addr_o[1:0]) + 2'd1); // R3
  AST_UPPER_FIXED: assert property (@(posedge clk_i) disable iff (rst_i)
    !load_i |=> $stable(word_addr_o[ADDR_W-1:2])); // R4
  AST_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
    (!load_i && adv_n_i) |=> $stable(word_addr_o)); // R5
  AST_RESET_ZERO: assert property (@(posedge clk_i)
    rst_i |=> word_addr_o == '0); // R8
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk_i(clk_i), .rst_i(rst_i), .load_i(load_i), .adv_n_i(adv_n_i),
  .ilv_mode_i(ilv_mode_i), .ext_addr_i(ext_addr_i), .word_addr_o(word_addr_o)
);

// File: tb/burst_addr_gen_tb.sv
module burst_addr_gen_tb_top;
  localparam int AW = 18;
  logic clk = 1'b0;
  logic rst, load, adv_n, mode;
  logic [AW-1:0] ext;
  logic [AW-1:0] waddr;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  burst_addr_gen #(.ADDR_W(AW)) dut_i (
    .clk_i(clk), .rst_i(rst), .load_i(load), .adv_n_i(adv_n),
    .ilv_mode_i(mode), .ext_addr_i(ext), .word_addr_o(waddr)
  );

  task automatic chk(input string req, input logic [AW-1:0] exp);
    checks++;
    if (waddr !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, waddr, exp);
    end
  endtask

  task automatic cyc(input logic l, input logic an, input logic [AW-1:0] a);
    @(negedge clk);
    load = l; adv_n = an; ext = a;
    @(posedge clk);
    #2;
  endtask

  function automatic logic [AW-1:0] model(input logic m, input logic [AW-1:0] b, input int k);
    logic [1:0] kk = 2'(k);
    return {b[AW-1:2], m ? (b[1:0] ^ kk) : 2'(b[1:0] + kk)};
  endfunction

  task automatic t_reset();
    rst = 1'b1; load = 1'b0; adv_n = 1'b1; mode = 1'b1; ext = '1;
    repeat (3) @(posedge clk);
    #2; chk("R8 reset", '0);
    @(negedge clk); rst = 1'b0;
    cyc(1'b0, 1'b0, '1);
    chk("R8 no load after reset", '0 ^ 18'h1);
  endtask

  task automatic t_burst(input logic m, input logic [AW-1:0] a, input string req);
    mode = m;
    cyc(1'b1, 1'b1, a);
    chk("R1 load", a);
    for (int k = 1; k < 9; k++) begin
      cyc(1'b0, 1'b0, ~a);
      chk(k < 4 ? req : "R6 wrap", model(m, a, k));
    end
  endtask

  task automatic t_carry();
    logic [AW-1:0] a = {{(AW-2){1'b1}}, 2'b11};
    mode = 1'b0;
    cyc(1'b1, 1'b1, a);
    cyc(1'b0, 1'b0, '0);
    chk("R4 no carry", {{(AW-2){1'b1}}, 2'b00});
  endtask

  task automatic t_hold();
    logic [AW-1:0] a = 18'h12340;
    mode = 1'b1;
    cyc(1'b1, 1'b1, a);
    cyc(1'b0, 1'b0, '0);
    for (int k = 0; k < 3; k++) begin
      cyc(1'b0, 1'b1, ~a);
      chk("R5 hold", model(1'b1, a, 1));
    end
    cyc(1'b0, 1'b0, '0);
    chk("R5 resume", model(1'b1, a, 2));
  endtask

  task automatic t_prio();
    logic [AW-1:0] a = 18'h0ABC1;
    logic [AW-1:0] b = 18'h3F00E;
    mode = 1'b0;
    cyc(1'b1, 1'b1, a);
    cyc(1'b0, 1'b0, '0);
    cyc(1'b0, 1'b0, '0);
    cyc(1'b1, 1'b0, b);
    chk("R7 load wins", b);
    cyc(1'b0, 1'b0, '0);
    chk("R1 position cleared", model(1'b0, b, 1));
  endtask

  initial begin
    t_reset();
    t_burst(1'b1, 18'h2A5B5, "R2 interleaved");
    t_burst(1'b1, 18'h00002, "R2 interleaved");
    t_burst(1'b0, 18'h3FFFE, "R3 linear");
    t_burst(1'b0, 18'h15551, "R3 linear");
    t_carry();
    t_hold();
    t_prio();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule